// File: doc/BRIEF.md
# Sign-Magnitude Restoring Divider

A sequential divider that takes a signed two's-complement dividend of twice the word width and a signed divisor of one word width. It returns a rounded signed quotient, the magnitude of the remainder, and two error flags. When the operands are accepted, the signs are stripped off and kept apart. The divider works only on magnitudes, held in an upper/lower register pair for the dividend and in one register for the divisor. The quotient sign is applied as the final step.

Three tests run before any iteration and settle some operations early. A zero divisor, a quotient that cannot fit in one word, and a dividend smaller than the divisor all finish without iterating. Every other operation runs one restoring shift-and-subtract step per quotient bit. A rounding step follows, and then the sign is applied. The `done` output pulses for one cycle when the results are ready, whatever the outcome.

Top module: `srDivider`

## Requirements
- R1: Operands are two's complement (dividend 2N bits, divisor N bits). The quotient output is an N+1-bit two's-complement value. Its sign is the XOR of the two operand sign bits, and a zero quotient reads as all zeros.
- R2: A zero divisor sets divZero=1 and overflow=0, with quotient and remainder zero. This test takes priority over every other outcome.
- R3: When the divisor is nonzero and the upper N bits of |dividend| are at least |divisor|, overflow=1 and divZero=0, with quotient and remainder zero.
- R4: When the divisor is nonzero and |dividend| < |divisor|, the quotient is 0 and the remainder is |dividend|. No rounding is applied.
- R5: In all other cases the remainder is |dividend| mod |divisor|. The quotient magnitude is floor(|dividend|/|divisor|), plus one when twice the remainder is at least |divisor|.
- R6: When rounding would carry the quotient magnitude to 2^N, overflow=1 and quotient and remainder are zero.
- R7: Count the rising edge that samples start as edge 0. done is high after edge 1 for the R2, R3 and R4 outcomes, and after edge N+2 for the others.
- R8: done is high for exactly one cycle. The results stay stable after that until the next start is accepted.
- R9: Operands are captured at the edge that accepts start. start, dividend and divisor are ignored while an operation is in progress.
- R10: After reset, done, overflow and divZero are low, and quotient and remainder are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin an operation when idle |
| dividend | input | 2N | Signed dividend |
| divisor | input | N | Signed divisor |
| quotient | output | N+1 | Signed rounded quotient |
| remainder | output | N | Remainder magnitude |
| overflow | output | 1 | Quotient does not fit |
| divZero | output | 1 | Divisor was zero |
| done | output | 1 | One-cycle completion pulse |

## Verification
Results for the three early outcomes are due one edge after the start edge. Results for an iterated division are due N+2 edges after it. The bench counts falling edges from the start edge, records the index at which done first reads high, and compares that index with the latency for the outcome its reference model predicts. Outputs are compared at that falling edge, and again one cycle later, when done must be low and the quotient unchanged. For some runs the bench drives new operands and a second start three cycles into the operation, to show they are ignored.

// File: rtl/srDivPkg.sv
`timescale 1ns/1ps
package srDivPkg;
  typedef struct packed {
    logic load;
    logic check;
    logic step;
    logic round;
  } divStrobe_t;

  typedef enum logic [2:0] {
    S_IDLE,
    S_CHECK,
    S_STEP,
    S_ROUND,
    S_DONE
  } divState_t;
endpackage

// File: rtl/divCtrl.sv
`timescale 1ns/1ps
module divCtrl
  import srDivPkg::*;
#(
  parameter int N = 8
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       start,
  input  logic       preHit,
  output divStrobe_t strobe,
  output logic       done
);
  localparam int CNT_W = $clog2(N);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(N - 1);

  divState_t state, nextState;
  logic [CNT_W-1:0] stepCnt;

  always_comb begin
    strobe    = '0;
    nextState = state;
    case (state)
      S_IDLE: begin
        strobe.load = start;
        if (start) nextState = S_CHECK;
      end
      S_CHECK: begin
        strobe.check = 1'b1;
        nextState    = preHit ? S_DONE : S_STEP;
      end
      S_STEP: begin
        strobe.step = 1'b1;
        if (stepCnt == LAST) nextState = S_ROUND;
      end
      S_ROUND: begin
        strobe.round = 1'b1;
        nextState    = S_DONE;
      end
      default: nextState = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= S_IDLE;
      stepCnt <= '0;
    end else begin
      state <= nextState;
      if (strobe.check) stepCnt <= '0;
      else if (strobe.step) stepCnt <= stepCnt + 1'b1;
    end
  end

  assign done = (state == S_DONE);
endmodule

// File: rtl/divPath.sv
`timescale 1ns/1ps
module divPath
  import srDivPkg::*;
#(
  parameter int N = 8
) (
  input  logic           clk,
  input  logic           rstN,
  input  divStrobe_t     strobe,
  input  logic [2*N-1:0] dividend,
  input  logic [N-1:0]   divisor,
  output logic           preHit,
  output logic [N:0]     quotient,
  output logic [N-1:0]   remainder,
  output logic           overflow,
  output logic           divZero
);
  localparam int W = 2 * N;

  logic [N-1:0] aReg, qReg, bReg;
  logic         qSign;

  // operand magnitudes
  logic [W-1:0] dvdMag;
  logic [N-1:0] dsrMag;
  assign dvdMag = dividend[W-1] ? -dividend : dividend;
  assign dsrMag = divisor[N-1] ? -divisor : divisor;

  // pre-iteration tests
  logic isDz, isOvf, isTriv;
  assign isDz   = (bReg == '0);
  assign isOvf  = (aReg >= bReg);
  assign isTriv = (aReg == '0) && (qReg < bReg);
  assign preHit = isDz | isOvf | isTriv;

  // one restoring step
  logic [N:0]   partial;
  logic [N+1:0] trial;
  logic         trialNeg;
  assign partial  = {aReg, qReg[N-1]};
  assign trial    = {1'b0, partial} - {2'b00, bReg};
  assign trialNeg = trial[N+1];

  // rounding
  logic         roundUp;
  logic [N:0]   qInc;
  assign roundUp = ({aReg, 1'b0} >= {1'b0, bReg});
  assign qInc    = {1'b0, qReg} + {{N{1'b0}}, roundUp};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      aReg      <= '0;
      qReg      <= '0;
      bReg      <= '0;
      qSign     <= 1'b0;
      quotient  <= '0;
      remainder <= '0;
      overflow  <= 1'b0;
      divZero   <= 1'b0;
    end else begin
      if (strobe.load) begin
        aReg      <= dvdMag[W-1:N];
        qReg      <= dvdMag[N-1:0];
        bReg      <= dsrMag;
        qSign     <= dividend[W-1] ^ divisor[N-1];
        quotient  <= '0;
        remainder <= '0;
        overflow  <= 1'b0;
        divZero   <= 1'b0;
      end
      if (strobe.check) begin
        if (isDz)        divZero   <= 1'b1;
        else if (isOvf)  overflow  <= 1'b1;
        else if (isTriv) remainder <= qReg;
      end
      if (strobe.step) begin
        aReg <= trialNeg ? partial[N-1:0] : trial[N-1:0];
        qReg <= {qReg[N-2:0], ~trialNeg};
      end
      if (strobe.round) begin
        if (qInc[N]) begin
          overflow <= 1'b1;
        end else begin
          quotient  <= qSign ? -qInc : qInc;
          remainder <= aReg;
        end
      end
    end
  end
endmodule

// File: rtl/srDivider.sv
`timescale 1ns/1ps
module srDivider
  import srDivPkg::*;
#(
  parameter int N = 8
) (
  input  logic           clk,
  input  logic           rstN,
  input  logic           start,
  input  logic [2*N-1:0] dividend,
  input  logic [N-1:0]   divisor,
  output logic [N:0]     quotient,
  output logic [N-1:0]   remainder,
  output logic           overflow,
  output logic           divZero,
  output logic           done
);
  divStrobe_t strobe;
  logic       preHit;

  divCtrl #(.N(N)) u_ctrl (
    .clk   (clk),
    .rstN  (rstN),
    .start (start),
    .preHit(preHit),
    .strobe(strobe),
    .done  (done)
  );

  divPath #(.N(N)) u_path (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .dividend (dividend),
    .divisor  (divisor),
    .preHit   (preHit),
    .quotient (quotient),
    .remainder(remainder),
    .overflow (overflow),
    .divZero  (divZero)
  );
endmodule

// File: rtl/srDividerChk.sv
`timescale 1ns/1ps
module srDividerChk #(
  parameter int N = 8
) (
  input logic           clk,
  input logic           rstN,
  input logic           start,
  input logic [2*N-1:0] dividend,
  input logic [N-1:0]   divisor,
  input logic [N:0]     quotient,
  input logic [N-1:0]   remainder,
  input logic           overflow,
  input logic           divZero,
  input logic           done
);
  localparam int CW = $clog2(N + 3) + 1;

  logic          busy;
  logic [CW-1:0] cnt;
  logic          capSign;
  logic [N-1:0]  capBMag;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busy    <= 1'b0;
      cnt     <= '0;
      capSign <= 1'b0;
      capBMag <= '0;
    end else if (start && !busy) begin
      busy    <= 1'b1;
      cnt     <= '0;
      capSign <= dividend[2*N-1] ^ divisor[N-1];
      capBMag <= divisor[N-1] ? -divisor : divisor;
    end else if (busy) begin
      cnt <= cnt + 1'b1;
      if (done) busy <= 1'b0;
    end
  end

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done); // R8
  AST_DONE_ONLY_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    done |-> busy); // R9
  AST_LATENCY: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (cnt == CW'(1) || cnt == CW'(N + 2))); // R7
  AST_DZ_CLEAN: assert property (@(posedge clk) disable iff (!rstN)
    (done && divZero) |-> (!overflow && quotient == '0 && remainder == '0)); // R2
  AST_OVF_CLEAN: assert property (@(posedge clk) disable iff (!rstN)
    (done && overflow) |-> (quotient == '0 && remainder == '0)); // R3
  AST_REM_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    (done && !overflow && !divZero) |-> (remainder < capBMag)); // R5
  AST_QUOT_SIGN: assert property (@(posedge clk) disable iff (!rstN)
    (done && quotient != '0) |-> (quotient[N] == capSign)); // R1
  AST_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    done |=> $stable(quotient) && $stable(remainder)); // R8
endmodule

bind srDivider srDividerChk #(.N(N)) i_chk (.*);

// File: tb/test_srDivider.sv
`timescale 1ns/1ps
module test_srDivider;
  localparam int N = 8;

  logic           clk = 1'b0;
  logic           rstN = 1'b0;
  logic           start = 1'b0;
  logic [2*N-1:0] dividend = '0;
  logic [N-1:0]   divisor = '0;
  logic [N:0]     quotient;
  logic [N-1:0]   remainder;
  logic           overflow, divZero, done;

  int nChecks = 0;
  int nFail   = 0;

  always #2.5 clk = ~clk;

  srDivider #(.N(N)) i_srDivider (
    .clk(clk), .rstN(rstN), .start(start), .dividend(dividend),
    .divisor(divisor), .quotient(quotient), .remainder(remainder),
    .overflow(overflow), .divZero(divZero), .done(done)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic refModel(input logic [2*N-1:0] x, input logic [N-1:0] y,
                          output logic [N:0] eq, output logic [N-1:0] er,
                          output logic eo, output logic ez, output int lat);
    longint xv, yv, am, bm, q, r;
    bit neg;
    xv = longint'($signed(x));
    yv = longint'($signed(y));
    am = xv < 0 ? -xv : xv;
    bm = yv < 0 ? -yv : yv;
    neg = (xv < 0) ^ (yv < 0);
    eq = '0; er = '0; eo = 1'b0; ez = 1'b0; lat = 1;
    if (bm == 0) ez = 1'b1;
    else if ((am >> N) >= bm) eo = 1'b1;
    else if (am < bm) er = N'(am);
    else begin
      lat = N + 2;
      q = am / bm;
      r = am % bm;
      if (2 * r >= bm) q++;
      if (q >= (longint'(1) << N)) eo = 1'b1;
      else begin
        eq = neg ? (N+1)'(-q) : (N+1)'(q);
        er = N'(r);
      end
    end
  endtask

  task automatic runCase(input logic [2*N-1:0] x, input logic [N-1:0] y, input bit disturb);
    logic [N:0]   eq;
    logic [N-1:0] er;
    logic         eo, ez;
    int           lat, idx;
    logic [N:0]   qSeen;
    refModel(x, y, eq, er, eo, ez, lat);
    dividend = x;
    divisor  = y;
    start    = 1'b1;
    @(negedge clk);
    idx = 0;
    while (!done && idx < 200) begin
      start = disturb && (idx == 3);
      if (disturb && idx == 3) begin   // R9: ignored while busy
        dividend = ~x;
        divisor  = ~y;
      end
      @(negedge clk);
      idx++;
    end
    start = 1'b0;
    if (!done) begin
      nChecks++; nFail++;
      $display("FAIL R7 watchdog actual=%0d expected=%0d", idx, lat);
      return;
    end
    chk(lat == 1 ? "R7 early latency" : "R7 iterate latency", idx, lat);
    chk(ez ? "R2 divZero" : "R2 divZero clear", divZero, ez);
    chk(eo ? (lat == 1 ? "R3 overflow" : "R6 round overflow") : "R3 overflow clear", overflow, eo);
    chk(lat == 1 ? "R4 quotient" : (disturb ? "R9 quotient" : "R5 R1 quotient"), quotient, eq);
    chk(lat == 1 ? "R4 remainder" : "R5 remainder", remainder, er);
    qSeen = quotient;
    @(negedge clk);
    chk("R8 done pulse", done, 1'b0);
    chk("R8 result hold", quotient, qSeen);
    @(negedge clk);
  endtask

  function automatic logic [2*N-1:0] sx(input longint v);
    return (2*N)'(v);
  endfunction

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    // R10: reset state
    chk("R10 done", done, 1'b0);
    chk("R10 quotient", quotient, '0);
    chk("R10 remainder", remainder, '0);
    chk("R10 flags", {overflow, divZero}, 2'b00);
    rstN = 1'b1;
    @(negedge clk);

    runCase(sx(100), 8'd0, 1'b0);              // R2
    runCase(sx(-100), 8'd0, 1'b0);             // R2
    runCase(sx(0), 8'd0, 1'b0);                // R2 priority over R3
    runCase(sx('h0500), 8'd5, 1'b0);           // R3 boundary A == B
    runCase(sx('h0400), 8'd5, 1'b0);           // R5 just below overflow, rounds
    runCase(sx(-'h0400), 8'd5, 1'b0);          // R1 negative
    runCase(sx(3), 8'd7, 1'b0);                // R4
    runCase(sx(-3), 8'd7, 1'b0);               // R4 remainder magnitude
    runCase(sx(767), 8'd3, 1'b0);              // R6 round carry
    runCase(sx(-32767), 8'h80, 1'b0);          // R6 with most negative divisor
    runCase(sx(100), 8'd7, 1'b0);              // R5 no rounding
    runCase(sx(100), 8'd8, 1'b0);              // R5 exact half rounds up
    runCase(sx(1000), 8'h80, 1'b0);            // R1 negative divisor
    runCase(sx(-1000), 8'hF9, 1'b1);           // R9 disturbed, both negative
    runCase(sx(-32768), 8'h80, 1'b0);          // R3 most negative operands

    for (int i = 0; i < 400; i++) begin
      int unsigned mode;
      logic [N-1:0] y;
      longint bm, am;
      logic [2*N-1:0] x;
      mode = $urandom % 4;
      y = N'($urandom);
      if (mode == 0) x = (2*N)'($urandom);
      else begin
        if (y == '0) y = 8'd1;
        bm = y[N-1] ? -longint'($signed(y)) : longint'(y);
        am = longint'($urandom % 32'(bm << N));
        x = ($urandom % 2 == 1) ? sx(-am) : sx(am);
      end
      runCase(x, y, mode == 2);
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFail);
    $finish;
  end
endmodule